// File: doc/BRIEF.md
# Triggered Pipeline Trace Buffer

This block keeps a rolling record of a processor pipeline inside a circular memory. On every clock it stores one sample. A sample holds an instruction-valid bit, a fetch-failure bit, a 36-bit packed instruction field and a group of auxiliary pipeline bits. The instruction field is packed in one of two ways. For a legal instruction it holds the predecoded opcode class in the upper bits and the low 26 bits of the instruction word below them. For an illegal instruction it sets a flag bit and keeps the whole 32-bit word.

Until a trigger arrives, the write address advances each cycle and wraps, so the oldest samples are overwritten. The first trigger after arming records the address of the trigger sample. Capture then continues for a fixed number of further samples and freezes. That number is the smaller of a quarter of the depth and 256, so a small buffer cannot wrap back over the event. A debug host reads the frozen contents through a synchronous read port. It then pulses `arm` to start a new capture.

Top module: `trace_log_buffer`

## Requirements
- R1: After reset, `triggered`, `stopped` and `trig_ptr` are 0 and the first sample is written at entry 0.
- R2: Before a trigger, each clock writes one entry at the next address modulo DEPTH, replacing the oldest data once the buffer has wrapped.
- R3: For a valid legal instruction (`smp_illegal`=0), instruction field bit 35 is 0, bits 34:26 hold `smp_code` and bits 25:0 hold `smp_word[25:0]`.
- R4: For a valid illegal instruction, bit 35 is 1, bits 34:32 are 0 and bits 31:0 hold the full `smp_word`.
- R5: Entry layout, from the MSB down: fetch-failed bit, instruction-valid bit, 36-bit instruction field, AUX_W auxiliary bits. When `smp_insn_valid` is 0 the instruction field is stored as all zeros.
- R6: The first `trig` seen while capturing sets `triggered` on the next edge and loads `trig_ptr` with the address the trigger sample was written to. Later triggers change nothing until the next arm.
- R7: After the trigger sample, exactly min(DEPTH/4, 256) more samples are written. `stopped` rises on the edge that writes the last of them, and no entry is written after that.
- R8: `rd_data` shows the entry at `rd_addr` as sampled on the previous clock edge (one cycle of latency).
- R9: `arm` returns the block to capture from any state. It clears `triggered`, `stopped` and `trig_ptr`, resets the write address to 0, and takes priority over `trig` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Clear and restart capture |
| trig | input | 1 | Trigger event |
| smp_insn_valid | input | 1 | Fetched instruction is valid |
| smp_fetch_fail | input | 1 | Fetch failed this cycle |
| smp_illegal | input | 1 | Instruction was decoded as illegal |
| smp_code | input | 9 | Predecoded instruction code |
| smp_word | input | 32 | Raw instruction word |
| smp_aux | input | AUX_W | Other pipeline bits stored verbatim |
| rd_addr | input | log2(DEPTH) | Host read address |
| rd_data | output | AUX_W+38 | Entry read, one cycle after the address |
| triggered | output | 1 | A trigger was accepted since the last arm |
| stopped | output | 1 | Post-trigger capture finished; buffer frozen |
| trig_ptr | output | log2(DEPTH) | Address holding the trigger sample |

## Verification
A wrong write pointer or post-trigger counter is not visible at once. It shows up only when the frozen buffer is read back: stored entries appear at shifted addresses, the wrapped region holds stale data, or `stopped` rises one cycle early or late relative to the trigger. The bench therefore tags each sample with a unique auxiliary value, counts the edges from trigger to stop, and reads back the boundary entries on both sides of the last write. Packing errors appear in the first read of an entry that holds a legal, illegal or invalid instruction. A second instance, deep enough for the 256-entry cap to apply, exposes a mistake in choosing the post-trigger length.

// File: rtl/trace_log_pkg.sv
package trace_log_pkg;

    localparam int INSN_W   = 36;
    localparam int CODE_W   = 9;
    localparam int WORD_W   = 32;
    localparam int LOW_W    = 26;
    localparam int ILL_BIT  = 35;
    localparam int POST_CAP = 256;

    typedef enum logic [1:0] {
        ST_CAPTURE = 2'd0,
        ST_POST    = 2'd1,
        ST_STOPPED = 2'd2
    } cap_state_e;

    function automatic int post_len(input int depth);
        int quarter;
        quarter = depth / 4;
        return (quarter < POST_CAP) ? quarter : POST_CAP;
    endfunction

endpackage

// File: rtl/trace_insn_packer.sv
module trace_insn_packer
    import trace_log_pkg::*;
(
    input  logic                valid_i,
    input  logic                illegal_i,
    input  logic [CODE_W-1:0]   code_i,
    input  logic [WORD_W-1:0]   word_i,
    output logic [INSN_W-1:0]   field_o
);

    localparam int PAD_W = INSN_W - 1 - WORD_W;

    always_comb begin
        field_o = '0;
        if (valid_i) begin
            if (illegal_i) begin
                field_o = {1'b1, {PAD_W{1'b0}}, word_i};
            end else begin
                field_o = {1'b0, code_i, word_i[LOW_W-1:0]};
            end
        end
    end

endmodule

// File: rtl/trace_ctrl.sv
module trace_ctrl
    import trace_log_pkg::*;
#(
    parameter  int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          trig,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic          triggered,
    output logic          stopped,
    output logic [AW-1:0] trig_ptr
);

    localparam int POST_LEN = post_len(DEPTH);
    localparam int CW       = $clog2(POST_LEN + 1);
    localparam logic [CW-1:0] POST_CNT = CW'(POST_LEN);

    typedef struct packed {
        cap_state_e    state;
        logic [AW-1:0] wptr;
        logic [AW-1:0] tptr;
        logic [CW-1:0] cnt;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        wr_en = 1'b0;
        if (arm) begin
            ctl_d.state = ST_CAPTURE;
            ctl_d.wptr  = '0;
            ctl_d.tptr  = '0;
            ctl_d.cnt   = '0;
        end else begin
            case (ctl_q.state)
                ST_CAPTURE: begin
                    wr_en      = 1'b1;
                    ctl_d.wptr = ctl_q.wptr + 1'b1;
                    if (trig) begin
                        ctl_d.state = ST_POST;
                        ctl_d.tptr  = ctl_q.wptr;
                        ctl_d.cnt   = POST_CNT;
                    end
                end
                ST_POST: begin
                    wr_en      = 1'b1;
                    ctl_d.wptr = ctl_q.wptr + 1'b1;
                    ctl_d.cnt  = ctl_q.cnt - 1'b1;
                    if (ctl_q.cnt == CW'(1)) begin
                        ctl_d.state = ST_STOPPED;
                    end
                end
                default: begin
                    ctl_d.state = ST_STOPPED;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_CAPTURE, wptr: '0, tptr: '0, cnt: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign wr_addr   = ctl_q.wptr;
    assign triggered = (ctl_q.state != ST_CAPTURE);
    assign stopped   = (ctl_q.state == ST_STOPPED);
    assign trig_ptr  = ctl_q.tptr;

endmodule

// File: rtl/trace_mem.sv
module trace_mem #(
    parameter  int DEPTH = 64,
    parameter  int W     = 46,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] store_q [DEPTH];
    logic [W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            store_q[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        rdata_q <= store_q[raddr];
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/trace_log_buffer.sv
module trace_log_buffer
    import trace_log_pkg::*;
#(
    parameter  int DEPTH   = 64,
    parameter  int AUX_W   = 8,
    localparam int AW      = $clog2(DEPTH),
    localparam int ENTRY_W = AUX_W + INSN_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm,
    input  logic               trig,
    input  logic               smp_insn_valid,
    input  logic               smp_fetch_fail,
    input  logic               smp_illegal,
    input  logic [CODE_W-1:0]  smp_code,
    input  logic [WORD_W-1:0]  smp_word,
    input  logic [AUX_W-1:0]   smp_aux,
    input  logic [AW-1:0]      rd_addr,
    output logic [ENTRY_W-1:0] rd_data,
    output logic               triggered,
    output logic               stopped,
    output logic [AW-1:0]      trig_ptr
);

    logic [INSN_W-1:0]  insn_field;
    logic [ENTRY_W-1:0] entry;
    logic               wr_en;
    logic [AW-1:0]      wr_ptr;

    trace_insn_packer u_pack (
        .valid_i   (smp_insn_valid),
        .illegal_i (smp_illegal),
        .code_i    (smp_code),
        .word_i    (smp_word),
        .field_o   (insn_field)
    );

    always_comb begin
        entry = {smp_fetch_fail, smp_insn_valid, insn_field, smp_aux};
    end

    trace_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .trig      (trig),
        .wr_en     (wr_en),
        .wr_addr   (wr_ptr),
        .triggered (triggered),
        .stopped   (stopped),
        .trig_ptr  (trig_ptr)
    );

    trace_mem #(.DEPTH(DEPTH), .W(ENTRY_W)) u_mem (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_ptr),
        .wdata (entry),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

endmodule

// File: rtl/trace_log_buffer_chk.sv
module trace_log_buffer_chk #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          arm,
    input logic          trig,
    input logic          triggered,
    input logic          stopped,
    input logic [AW-1:0] trig_ptr,
    input logic [AW-1:0] wptr
);

    // R7
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && !arm) |=> stopped);

    // R7
    stop_needs_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |-> triggered);

    // R7
    frozen_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && !arm) |=> $stable(wptr));

    // R2
    ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stopped && !arm) |=> (wptr == $past(wptr) + 1'b1));

    // R6
    tptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (triggered && !arm) |=> $stable(trig_ptr));

    // R6
    trig_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(triggered) |-> ($past(trig) && !$past(arm)));

    // R9
    arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (!triggered && !stopped && trig_ptr == '0 && wptr == '0));

endmodule

bind trace_log_buffer trace_log_buffer_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .trig      (trig),
    .triggered (triggered),
    .stopped   (stopped),
    .trig_ptr  (trig_ptr),
    .wptr      (wr_ptr)
);

// File: tb/trace_log_buffer_tb_top.sv
module trace_log_buffer_tb_top;

    localparam int DEPTH = 64;
    localparam int AW    = 6;
    localparam int EW    = 46;
    localparam int BIG_D = 2048;
    localparam int BIG_A = 11;
    localparam int POST  = 16;
    localparam int NV    = 7;

    localparam logic        V_VALID [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
    localparam logic        V_FAIL  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
    localparam logic        V_ILL   [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
    localparam logic [8:0]  V_CODE  [NV] = '{9'h1A3, 9'h1FF, 9'h000, 9'h001, 9'h005, 9'h1FF, 9'h1FF};
    localparam logic [31:0] V_WORD  [NV] = '{32'hDEADBEEF, 32'h12345678, 32'hFC000001,
                                             32'h03FFFFFF, 32'hFFFFFFFF, 32'h00000000,
                                             32'h00000000};
    localparam logic [35:0] V_EXP   [NV] = '{36'h68EADBEEF, 36'h812345678, 36'h000000001,
                                             36'h007FFFFFF, 36'h000000000, 36'h800000000,
                                             36'h7FC000000};
    localparam string       V_REQ   [NV] = '{"R3", "R4", "R3", "R3", "R5", "R4", "R3"};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arm = 1'b0;
    logic          trig = 1'b0;
    logic          trig2 = 1'b0;
    logic          s_valid = 1'b0;
    logic          s_fail = 1'b0;
    logic          s_ill = 1'b0;
    logic [8:0]    s_code = '0;
    logic [31:0]   s_word = '0;
    logic [7:0]    s_aux = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [EW-1:0] rd_data;
    logic          triggered, stopped;
    logic [AW-1:0] trig_ptr;
    logic [EW-1:0] rd_data2;
    logic          triggered2, stopped2;
    logic [BIG_A-1:0] trig_ptr2;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    trace_log_buffer #(.DEPTH(DEPTH), .AUX_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .arm(arm), .trig(trig),
        .smp_insn_valid(s_valid), .smp_fetch_fail(s_fail), .smp_illegal(s_ill),
        .smp_code(s_code), .smp_word(s_word), .smp_aux(s_aux),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .triggered(triggered), .stopped(stopped), .trig_ptr(trig_ptr)
    );

    trace_log_buffer #(.DEPTH(BIG_D), .AUX_W(8)) dut_big_i (
        .clk(clk), .rst_n(rst_n), .arm(arm), .trig(trig2),
        .smp_insn_valid(s_valid), .smp_fetch_fail(s_fail), .smp_illegal(s_ill),
        .smp_code(s_code), .smp_word(s_word), .smp_aux(s_aux),
        .rd_addr('0), .rd_data(rd_data2),
        .triggered(triggered2), .stopped(stopped2), .trig_ptr(trig_ptr2)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic plain(input logic [7:0] aux);
        s_valid = 1'b0; s_fail = 1'b0; s_ill = 1'b0;
        s_code = '0; s_word = '0; s_aux = aux;
    endtask

    task automatic read_chk(input logic [AW-1:0] a, input logic [EW-1:0] exp,
                            input string req);
        rd_addr = a;
        tick();
        chk(rd_data === exp, req, 64'(rd_data), 64'(exp));
    endtask

    function automatic logic [EW-1:0] plain_entry(input logic [7:0] aux);
        return {2'b00, 36'h0, aux};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #1;
        tick(); tick();
        rst_n = 1'b1;
        // R1 reset state
        chk(!triggered && !stopped, "R1", {triggered, stopped}, 0);
        chk(trig_ptr == 0, "R1", 64'(trig_ptr), 0);

        // Vector table: one sample per entry, starting at address 0 (R1, R2)
        for (int i = 0; i < NV; i++) begin
            s_valid = V_VALID[i]; s_fail = V_FAIL[i]; s_ill = V_ILL[i];
            s_code = V_CODE[i]; s_word = V_WORD[i]; s_aux = 8'(i);
            tick();
        end

        // trigger sample lands at address NV (R6)
        plain(8'hA0);
        trig = 1'b1;
        tick();
        trig = 1'b0;
        chk(triggered === 1'b1, "R6", 64'(triggered), 1);
        chk(trig_ptr == AW'(NV), "R6", 64'(trig_ptr), NV);

        // post-trigger samples; a second trigger is ignored (R6, R7)
        for (int j = 0; j < POST - 1; j++) begin
            plain(8'hB0 + 8'(j));
            trig = (j == 3);
            tick();
        end
        trig = 1'b0;
        chk(stopped === 1'b0, "R7", 64'(stopped), 0);
        plain(8'hB0 + 8'(POST - 1));
        tick();
        chk(stopped === 1'b1, "R7", 64'(stopped), 1);
        chk(trig_ptr == AW'(NV), "R6", 64'(trig_ptr), NV);

        // frozen: new samples must not be written
        plain(8'hEE);
        tick(); tick(); tick();

        for (int i = 0; i < NV; i++) begin
            read_chk(AW'(i), {V_FAIL[i], V_VALID[i], V_EXP[i], 8'(i)}, V_REQ[i]);
        end
        read_chk(AW'(NV), plain_entry(8'hA0), "R6");
        read_chk(AW'(NV + POST), plain_entry(8'hB0 + 8'(POST - 1)), "R7");

        // R8: one cycle of latency
        rd_addr = AW'(1);
        tick();
        rd_addr = AW'(0);
        chk(rd_data === {1'b0, 1'b1, V_EXP[1], 8'd1}, "R8", 64'(rd_data), 0);
        tick();
        chk(rd_data === {1'b0, 1'b1, V_EXP[0], 8'd0}, "R8", 64'(rd_data), 0);

        // R9: arm beats a same-cycle trigger
        arm = 1'b1; trig = 1'b1;
        tick();
        arm = 1'b0; trig = 1'b0;
        chk(!triggered && !stopped, "R9", {triggered, stopped}, 0);
        chk(trig_ptr == 0, "R9", 64'(trig_ptr), 0);

        // R2: wrap past the depth, then trigger
        for (int i = 0; i < DEPTH + 6; i++) begin
            plain(8'(i));
            tick();
        end
        plain(8'(DEPTH + 6));
        trig = 1'b1;
        tick();
        trig = 1'b0;
        chk(trig_ptr == AW'(6), "R6", 64'(trig_ptr), 6);
        for (int j = 0; j < POST; j++) begin
            plain(8'(DEPTH + 7 + j));
            tick();
        end
        chk(stopped === 1'b1, "R7", 64'(stopped), 1);
        read_chk(AW'(0), plain_entry(8'(DEPTH)), "R2");
        read_chk(AW'(5), plain_entry(8'(DEPTH + 5)), "R2");
        read_chk(AW'(22), plain_entry(8'(DEPTH + 22)), "R7");
        read_chk(AW'(23), plain_entry(8'd23), "R7");
        read_chk(AW'(63), plain_entry(8'd63), "R2");

        // R7: deep buffer caps the post-trigger run at 256
        begin
            int n;
            n = 0;
            trig2 = 1'b1;
            tick();
            trig2 = 1'b0;
            chk(triggered2 === 1'b1, "R6", 64'(triggered2), 1);
            while (!stopped2 && n < 400) begin
                tick();
                n++;
            end
            chk(n == 256, "R7", 64'(n), 256);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule